// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This block holds the handshake control register and the handshake status register of a 16550-style serial port. Four asynchronous handshake inputs (clear-to-send, data-set-ready, carrier-detect and ring) are each synchronised. They are then compared sample by sample, and every change is latched into a sticky change flag. The change flags stay set until the status register is read. Any set change flag raises a modem-status interrupt request.

The control register drives four handshake outputs: request-to-send, terminal-ready and two general-purpose outputs. A loopback bit in the control register makes the status read value come from those outputs instead of from the external pins. While loopback is on, reads do not clear the change flags. The host reads `stat_rdata` combinationally and gives a one-cycle `stat_rd` strobe to consume the read. Interrupt prioritisation and the serial data path belong to other blocks.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status read value is 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control readback is 0x08 (only OUT2 set), and the interrupt request is low.
- R2: The status read value has carrier-detect in bit 7, ring in bit 6, data-set-ready in bit 5 and clear-to-send in bit 4. Each of these follows its synchronised input pin.
- R3: Change flags are in bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send). Each one sets when its status bit differs from the previous sample, and it stays set until it is cleared.
- R4: Bit 2 (trailing ring edge) sets only when ring goes from 1 to 0. A rise of ring leaves it clear.
- R5: A status read strobe outside loopback clears bits 3:0 at the next clock edge and leaves bits 7:4 unchanged.
- R6: `msi_irq` is high exactly while any of the four change flags is set.
- R7: A control write stores the 5-bit value: loopback bit 4, OUT2 bit 3, OUT1 bit 2, request-to-send bit 1, terminal-ready bit 0. The value is read back as written, and it drives the four output pins after the next clock edge.
- R8: In loopback the status read value has OUT2 in bit 7, OUT1 in bit 6, terminal-ready in bit 5, request-to-send in bit 4, and zero in bits 3:0.
- R9: A status read strobe during loopback leaves every change flag as it was.
- R10: A change on an input pin reaches the status register only at the third rising clock edge after it is applied: two synchroniser flops, then the sample register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write value |
| ctrl_rdata | output | 5 | Control register readback |
| stat_rd | input | 1 | Status read consume strobe |
| stat_rdata | output | 8 | Status read value |
| cts_pin | input | 1 | Clear-to-send input, asynchronous |
| dsr_pin | input | 1 | Data-set-ready input, asynchronous |
| dcd_pin | input | 1 | Carrier-detect input, asynchronous |
| ri_pin | input | 1 | Ring input, asynchronous |
| rts_pin | output | 1 | Request-to-send output |
| dtr_pin | output | 1 | Terminal-ready output |
| out1_pin | output | 1 | General-purpose output 1 |
| out2_pin | output | 1 | General-purpose output 2 |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the read and write strobes are clean single-cycle pulses at clock edges. They also assume that the handshake pins hold steady long enough to pass both synchroniser flops, so every change the properties reason about is a change of the sampled value. The stimulus drives pins and strobes only on falling clock edges. It holds each pin pattern for at least three rising edges before it checks a result, and it never pulses a strobe in the cycle in which a synchronised change lands.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int LINES = 4;
  localparam int CTRL_W = 5;
  // status nibble order {carrier, ring, ready, clear}
  localparam logic [LINES-1:0] STAT_RESET = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b01000;
  localparam int LOOP_BIT = 4;

  // change flags: ring reports only its falling edge
  function automatic logic [LINES-1:0] change_flags(input logic [LINES-1:0] prev,
                                                   input logic [LINES-1:0] now);
    logic [LINES-1:0] f;
    f = prev ^ now;
    f[2] = prev[2] & ~now[2];
    return f;
  endfunction

  // loopback cross-map of output bits onto the status nibble
  function automatic logic [LINES-1:0] loop_map(input logic [CTRL_W-1:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sample,
  input  logic             clr_req,
  output logic [LINES-1:0] stat,
  output logic [LINES-1:0] delta,
  output logic [LINES-1:0] evt
);
  assign evt = change_flags(stat, sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= STAT_RESET;
      delta <= '0;
    end else begin
      stat  <= sample;
      delta <= (clr_req ? '0 : delta) | evt;
    end
  end

  assert_teri_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta[2]) |-> ($past(stat[2]) && !$past(sample[2])));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((delta & $past(delta)) == $past(delta)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && evt == '0) |=> (delta == '0 && $stable(stat)));
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= CTRL_RESET;
    else if (wr) ctrl <= wdata;
  end

  assert_ctrl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl == $past(wdata)));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctrl));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              stat_rd,
  output logic [7:0]        stat_rdata,
  input  logic              cts_pin,
  input  logic              dsr_pin,
  input  logic              dcd_pin,
  input  logic              ri_pin,
  output logic              rts_pin,
  output logic              dtr_pin,
  output logic              out1_pin,
  output logic              out2_pin,
  output logic              msi_irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [LINES-1:0]  pins_sync, stat, delta, evt;
  logic              loop_on, clr_req;

  msu_ctrl u_ctrl (.clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata), .ctrl(ctrl));

  msu_sync #(.W(LINES), .STAGES(SYNC_STAGES), .INIT(STAT_RESET)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dcd_pin, ri_pin, dsr_pin, cts_pin}), .q(pins_sync));

  assign loop_on = ctrl[LOOP_BIT];
  assign clr_req = stat_rd & ~loop_on;

  msu_delta u_delta (.clk(clk), .rst_n(rst_n), .sample(pins_sync), .clr_req(clr_req),
                     .stat(stat), .delta(delta), .evt(evt));

  assign stat_rdata = loop_on ? {loop_map(ctrl), 4'b0000} : {stat, delta};
  assign ctrl_rdata = ctrl;
  assign rts_pin    = ctrl[1];
  assign dtr_pin    = ctrl[0];
  assign out1_pin   = ctrl[2];
  assign out2_pin   = ctrl[3];
  assign msi_irq    = |delta;

  assert_loop_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && loop_on) |=> ((delta & $past(delta)) == $past(delta)));

  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !loop_on && evt == '0) |=> !msi_irq);

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> msi_irq);
endmodule

// File: tb/modem_status_unit_test.sv
`timescale 1ns/100ps
module modem_status_unit_test;
  logic clk = 0, rst_n = 0;
  logic ctrl_wr = 0, stat_rd = 0;
  logic [4:0] ctrl_wdata = '0;
  logic [4:0] ctrl_rdata;
  logic [7:0] stat_rdata;
  logic cts_pin = 1, dsr_pin = 1, dcd_pin = 1, ri_pin = 0;
  logic rts_pin, dtr_pin, out1_pin, out2_pin, msi_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_status_unit uut (.*);

  // {pins dcd,ri,dsr,cts ; expected status ; consume}
  localparam logic [12:0] VEC [6] = '{
    {4'b1011, 8'hB0, 1'b1},   // R2 idle levels
    {4'b1010, 8'hA1, 1'b1},   // R3 clear-to-send drop
    {4'b1110, 8'hE0, 1'b0},   // R4 ring rise: no flag
    {4'b1010, 8'hA4, 1'b0},   // R4 ring fall: flag
    {4'b0000, 8'h0E, 1'b1},   // R3 accumulate carrier and ready
    {4'b1111, 8'hFB, 1'b1}    // R3 all rise, ring rise adds nothing
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic [3:0] v);
    {dcd_pin, ri_pin, dsr_pin, cts_pin} = v;
  endtask

  task automatic consume();
    stat_rd = 1; step(1); stat_rd = 0;
  endtask

  task automatic wctrl(input logic [4:0] v);
    ctrl_wr = 1; ctrl_wdata = v; step(1); ctrl_wr = 0;
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1 status", stat_rdata, 8'hB0);
    chk("R1 control", {3'b0, ctrl_rdata}, 8'h08);
    chk("R1 irq/pins", {3'b0, msi_irq, out2_pin, out1_pin, rts_pin, dtr_pin}, 8'h08);

    for (int i = 0; i < 6; i++) begin
      pins(VEC[i][12:9]);
      step(3);
      chk("R2/R3/R4 status", stat_rdata, VEC[i][8:1]);
      chk("R6 irq", {7'b0, msi_irq}, {7'b0, |VEC[i][4:1]});
      if (VEC[i][0]) begin
        consume();
        chk("R5 after read", stat_rdata, {VEC[i][8:5], 4'h0});
        chk("R6 irq after read", {7'b0, msi_irq}, 8'h00);
      end
    end

    pins(4'b1110); step(3);
    chk("R3 pending flag", stat_rdata, 8'hE1);
    wctrl(5'h15);
    chk("R7 readback", {3'b0, ctrl_rdata}, 8'h15);
    chk("R7 pins", {4'b0, out2_pin, out1_pin, rts_pin, dtr_pin}, 8'h05);
    chk("R8 loop map", stat_rdata, 8'h60);
    consume();
    chk("R8 loop map after read", stat_rdata, 8'h60);
    wctrl(5'h08);
    chk("R9 flags kept", stat_rdata, 8'hE1);
    chk("R9 irq kept", {7'b0, msi_irq}, 8'h01);
    wctrl(5'h1A);
    chk("R8 loop other bits", stat_rdata, 8'h90);
    wctrl(5'h03);
    chk("R7 rts/dtr", {4'b0, out2_pin, out1_pin, rts_pin, dtr_pin}, 8'h03);
    consume();
    chk("R5 clear", stat_rdata, 8'hE0);

    pins(4'b1100); step(2);
    chk("R10 not yet", stat_rdata, 8'hE0);
    step(1);
    chk("R10 landed", stat_rdata, 8'hC2);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule